// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single machine cycles on a narrow external bus where the lower address byte and the data byte share one set of lines. A request carries a three-bit cycle code and a 16-bit address, plus a byte to write. The sequencer steps through the T-states of the cycle. It drives the upper address byte and the shared lines with their output enables, a latch strobe in the first state, the right active-low strobe, and a three-bit status (IO/M select plus two status bits). It captures the read byte at the close of the cycle.

The states are IDLE, T1, T2, TW (wait), T3, HOLD and HALT. The transitions are as follows. T1 always goes to T2. From T2 or TW the block goes to TW while `ready` is low and to T3 once it is high. IDLE, T3 and HALT are cycle boundaries. At a boundary a high `hold` moves to HOLD. Otherwise a valid request moves to T1. Otherwise a high `halt_req` moves to HALT. Otherwise the block goes to IDLE. HOLD returns to IDLE in the clock after `hold` is seen low. Outputs are decoded from the state and the latched request, so they change in the same clock as the state.

Top module: `bus_cycle_seq`

## Requirements
- R1: In T1, `ale` is 1, `ad_oe` is 1, `ad_o` carries address bits 7:0, `addr_hi` carries address bits 15:8 and `addr_hi_oe` is 1. `ale` is 0 in every other state.
- R2: From T1 through T3, {`io_m`,`s1`,`s0`} equals the request code: 011 opcode fetch, 010 memory read, 001 memory write, 110 I/O read, 101 I/O write, 111 interrupt acknowledge.
- R3: From T2 through T3 (waits included), exactly one strobe is low. `rd_n` is low for codes 011, 010 and 110, `wr_n` for 001 and 101, and `inta_n` for 111. All strobes are high in T1 and outside cycles.
- R4: In T2, TW and T3, `ad_oe` is 1 and `ad_o` carries the write byte only for codes 001 and 101. For every other code `ad_oe` is 0.
- R5: `ready` is sampled at the end of T2 and of each TW. Each low sample adds one TW state, and the strobe stays asserted through it.
- R6: For codes other than 001 and 101, `rd_data` takes `ad_i` at the end of T3. `cyc_done` is 1 for exactly the one clock after T3, for every cycle type.
- R7: `hold` is acted on only at a cycle boundary, so a cycle in progress completes. In HOLD, `hlda` is 1 and `ad_oe`, `addr_hi_oe`, `ctrl_oe` and `iom_oe` are 0, and requests do not start cycles.
- R8: One clock after `hold` is seen low in HOLD, `hlda` is 0 and `ctrl_oe` and `iom_oe` are 1.
- R9: In HALT, `s1`,`s0` are 00, `iom_oe` is 0, `addr_hi_oe` is 0 and `ctrl_oe` is 1.
- R10: While `rst_n` is low, `addr_hi_oe`, `ad_oe`, `ctrl_oe` and `iom_oe` are 0. After reset the block is idle with all strobes high and `hlda` 0.
- R11: Requests with codes 000 or 100 are ignored: no T1 follows (`ale` stays 0).
- R12: A valid request present at the end of T3 starts the next T1 in the following clock, with no idle clock between.
- R13: At a boundary, `hold` wins over a request, and a request wins over `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, taken at a boundary |
| req_code | input | 3 | Cycle code {IO/M,S1,S0} |
| req_addr | input | 16 | Cycle address |
| wr_data | input | 8 | Byte for write cycles |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | External master bus request |
| halt_req | input | 1 | Enter halt when idle |
| ad_i | input | 8 | Shared lines, input side |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe | output | 1 | Shared line output enable |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Upper address output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| ctrl_oe | output | 1 | Enable for strobes and status bits |
| io_m | output | 1 | IO/M select |
| iom_oe | output | 1 | IO/M output enable |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| hlda | output | 1 | Bus granted to external master |
| rd_data | output | 8 | Byte captured at end of read-type cycles |
| cyc_done | output | 1 | One-clock pulse after T3 |

## Verification
The assertions assume `hold` is a level that stays high until `hlda` has been seen. They also assume `ready` and `ad_i` settle before the clock edge on which they are sampled. The bench changes every input only on the falling clock edge. It keeps `hold` high for several clocks and releases it only while HOLD is granted, so the inputs stay within those assumptions.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HOLD, ST_HALT
    } bcs_state_t;

    localparam logic [2:0] CODE_FETCH = 3'b011;
    localparam logic [2:0] CODE_MRD   = 3'b010;
    localparam logic [2:0] CODE_MWR   = 3'b001;
    localparam logic [2:0] CODE_IORD  = 3'b110;
    localparam logic [2:0] CODE_IOWR  = 3'b101;
    localparam logic [2:0] CODE_ACK   = 3'b111;

    typedef struct packed {
        logic ok;
        logic rd;
        logic wr;
        logic ack;
    } bcs_class_t;
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
    import bcs_pkg::*;
(
    input  logic [2:0] code,
    output bcs_class_t cls
);
    always_comb begin
        cls = '0;
        unique case (code)
            CODE_FETCH, CODE_MRD, CODE_IORD: begin cls.ok = 1'b1; cls.rd = 1'b1; end
            CODE_MWR, CODE_IOWR:             begin cls.ok = 1'b1; cls.wr = 1'b1; end
            CODE_ACK:                        begin cls.ok = 1'b1; cls.ack = 1'b1; end
            default:                         cls = '0;
        endcase
    end
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       hold,
    input  logic       halt_req,
    input  logic       ready,
    output bcs_state_t state,
    output logic       accept
);
    bcs_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE, ST_T3, ST_HALT: begin
                if (hold)          nxt = ST_HOLD;
                else if (go)       begin nxt = ST_T1; accept = 1'b1; end
                else if (halt_req) nxt = ST_HALT;
                else               nxt = ST_IDLE;
            end
            ST_T1:          nxt = ST_T2;
            ST_T2, ST_TW:   nxt = ready ? ST_T3 : ST_TW;
            ST_HOLD:        nxt = hold ? ST_HOLD : ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bcs_state_t        state,
    input  logic              accept,
    input  logic [2:0]        req_code,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              addr_hi_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              ctrl_oe,
    output logic              io_m,
    output logic              iom_oe,
    output logic              s1,
    output logic              s0,
    output logic              hlda,
    output logic [DATA_W-1:0] rd_data,
    output logic              cyc_done
);
    logic [2:0]        cur_code;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    bcs_class_t        cls;
    logic              in_cyc, strobe_ph;

    bcs_decode u_cur_dec (.code(cur_code), .cls(cls));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_code  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rd_data   <= '0;
            cyc_done  <= 1'b0;
        end else begin
            if (accept) begin
                cur_code  <= req_code;
                cur_addr  <= req_addr;
                cur_wdata <= wr_data;
            end
            if (state == ST_T3 && !cls.wr) rd_data <= ad_i;
            cyc_done <= (state == ST_T3);
        end
    end

    always_comb begin
        in_cyc     = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
        strobe_ph  = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
        ale        = (state == ST_T1);
        ad_oe      = rst_n && ((state == ST_T1) || (strobe_ph && cls.wr));
        ad_o       = (state == ST_T1) ? cur_addr[DATA_W-1:0] : cur_wdata;
        addr_hi    = cur_addr[ADDR_W-1:DATA_W];
        addr_hi_oe = rst_n && in_cyc;
        rd_n       = !(strobe_ph && cls.rd);
        wr_n       = !(strobe_ph && cls.wr);
        inta_n     = !(strobe_ph && cls.ack);
        ctrl_oe    = rst_n && (state != ST_HOLD);
        iom_oe     = rst_n && (state != ST_HOLD) && (state != ST_HALT);
        {io_m, s1, s0} = in_cyc ? cur_code : 3'b000;
        hlda       = (state == ST_HOLD);
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ready,
    input  logic              hold,
    input  logic              halt_req,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              addr_hi_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              ctrl_oe,
    output logic              io_m,
    output logic              iom_oe,
    output logic              s1,
    output logic              s0,
    output logic              hlda,
    output logic [DATA_W-1:0] rd_data,
    output logic              cyc_done
);
    bcs_class_t req_cls;
    bcs_state_t state;
    logic       accept;
    logic       go;

    bcs_decode u_req_dec (.code(req_code), .cls(req_cls));

    assign go = req_valid && req_cls.ok;

    bcs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .hold(hold),
        .halt_req(halt_req), .ready(ready), .state(state), .accept(accept)
    );

    bcs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
        .req_code(req_code), .req_addr(req_addr), .wr_data(wr_data), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe(ad_oe), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .ctrl_oe(ctrl_oe),
        .io_m(io_m), .iom_oe(iom_oe), .s1(s1), .s0(s0), .hlda(hlda),
        .rd_data(rd_data), .cyc_done(cyc_done)
    );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic inta_n,
    input logic ad_oe,
    input logic addr_hi_oe,
    input logic ctrl_oe,
    input logic iom_oe,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic hlda,
    input logic cyc_done
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R1
    AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && (!rd_n || !wr_n || !inta_n)) |-> $stable({io_m, s1, s0})); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rd_n, ~wr_n, ~inta_n})); // R3
    AST_NO_STROBE_AT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cyc_done |=> !cyc_done); // R6
    AST_GRANT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !addr_hi_oe && !ctrl_oe && !iom_oe)); // R7
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold)); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> !hlda); // R8
    AST_HALT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_oe && !iom_oe) |-> ({s1, s0} == 2'b00 && !addr_hi_oe)); // R9
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hold(hold), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .inta_n(inta_n), .ad_oe(ad_oe), .addr_hi_oe(addr_hi_oe), .ctrl_oe(ctrl_oe),
    .iom_oe(iom_oe), .io_m(io_m), .s1(s1), .s0(s0), .hlda(hlda), .cyc_done(cyc_done)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_code = 3'b000;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  wr_data = 8'h0;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        halt_req = 1'b0;
    logic [7:0]  ad_i = 8'h0;
    logic [7:0]  ad_o, addr_hi, rd_data;
    logic        ad_oe, addr_hi_oe, ale, rd_n, wr_n, inta_n, ctrl_oe;
    logic        io_m, iom_oe, s1, s0, hlda, cyc_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_addr(req_addr), .wr_data(wr_data), .ready(ready), .hold(hold),
        .halt_req(halt_req), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n), .ctrl_oe(ctrl_oe), .io_m(io_m),
        .iom_oe(iom_oe), .s1(s1), .s0(s0), .hlda(hlda), .rd_data(rd_data),
        .cyc_done(cyc_done)
    );

    // code, addr, wdata, rdata, waits
    localparam int NV = 7;
    localparam logic [38:0] VEC [NV] = '{
        {3'b011, 16'h1234, 8'h00, 8'h5A, 4'd0},
        {3'b010, 16'hA0C3, 8'h00, 8'hC7, 4'd2},
        {3'b001, 16'h2100, 8'h3A, 8'h00, 4'd0},
        {3'b110, 16'h00F0, 8'h00, 8'h81, 4'd1},
        {3'b101, 16'h0042, 8'hE5, 8'h00, 4'd3},
        {3'b111, 16'hFFEE, 8'h00, 8'h24, 4'd0},
        {3'b001, 16'h8001, 8'h96, 8'h00, 4'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_strobes(input logic [2:0] c);
        if (c == 3'b001 || c == 3'b101) return 3'b101;
        if (c == 3'b111)                return 3'b110;
        return 3'b011;
    endfunction

    task automatic run_cycle(input logic [2:0] c, input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rv, input int waits, input bit chain);
        bit is_wr;
        is_wr = (c == 3'b001 || c == 3'b101);
        if (!chain) begin
            req_valid = 1'b1; req_code = c; req_addr = a; wr_data = wd;
            tick();
        end
        // T1
        req_valid = 1'b0;
        chk("R1 ale", ale, 1'b1);
        chk("R1 ad_oe", ad_oe, 1'b1);
        chk("R1 ad_o", ad_o, a[7:0]);
        chk("R1 addr_hi", {addr_hi_oe, addr_hi}, {1'b1, a[15:8]});
        chk("R2 status T1", {io_m, s1, s0}, c);
        chk("R3 no strobe T1", {rd_n, wr_n, inta_n}, 3'b111);
        ready = (waits == 0);
        tick();
        // T2
        chk("R1 ale low", ale, 1'b0);
        chk("R3 strobe T2", {rd_n, wr_n, inta_n}, exp_strobes(c));
        chk("R4 ad_oe T2", ad_oe, is_wr);
        if (is_wr) chk("R4 ad_o T2", ad_o, wd);
        for (int i = 0; i < waits; i++) begin
            tick();
            chk("R5 strobe in wait", {rd_n, wr_n, inta_n}, exp_strobes(c));
            chk("R5 status in wait", {io_m, s1, s0}, c);
            ready = (i == waits - 1);
        end
        tick();
        // T3
        chk("R3 strobe T3", {rd_n, wr_n, inta_n}, exp_strobes(c));
        chk("R2 status T3", {io_m, s1, s0}, c);
        ad_i = rv;
    endtask

    task automatic finish_cycle(input logic [2:0] c, input logic [7:0] rv);
        tick();
        chk("R6 done", cyc_done, 1'b1);
        if (!(c == 3'b001 || c == 3'b101)) chk("R6 rd_data", rd_data, rv);
        chk("R3 strobes idle", {rd_n, wr_n, inta_n}, 3'b111);
        tick();
        chk("R6 done single", cyc_done, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R10 during reset
        @(negedge clk);
        chk("R10 reset oe", {addr_hi_oe, ad_oe, ctrl_oe, iom_oe}, 4'b0000);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10 idle strobes", {rd_n, wr_n, inta_n, hlda}, 4'b1110);
        chk("R10 idle enables", {ctrl_oe, iom_oe, ale}, 3'b110);

        // vector table
        for (int v = 0; v < NV; v++) begin
            run_cycle(VEC[v][38:36], VEC[v][35:20], VEC[v][19:12], VEC[v][11:4], int'(VEC[v][3:0]), 1'b0);
            finish_cycle(VEC[v][38:36], VEC[v][11:4]);
        end

        // R11 invalid codes
        req_valid = 1'b1; req_code = 3'b000; req_addr = 16'h5555;
        tick();
        chk("R11 code 000 ignored", ale, 1'b0);
        req_code = 3'b100;
        tick();
        chk("R11 code 100 ignored", ale, 1'b0);
        req_valid = 1'b0;
        tick();

        // R12 back-to-back
        run_cycle(3'b010, 16'h3344, 8'h00, 8'h11, 0, 1'b0);
        req_valid = 1'b1; req_code = 3'b001; req_addr = 16'h7788; wr_data = 8'h99;
        tick();
        chk("R12 immediate T1", ale, 1'b1);
        chk("R12 done with T1", cyc_done, 1'b1);
        chk("R12 prior rd_data", rd_data, 8'h11);
        run_cycle(3'b001, 16'h7788, 8'h99, 8'h00, 0, 1'b1);
        finish_cycle(3'b001, 8'h00);

        // R7 hold during a cycle
        req_valid = 1'b1; req_code = 3'b011; req_addr = 16'h4000;
        tick();
        req_valid = 1'b0;
        hold = 1'b1;
        tick();
        chk("R7 no grant mid-cycle T2", hlda, 1'b0);
        tick();
        chk("R7 cycle completes T3", {rd_n, hlda}, 2'b00);
        req_valid = 1'b1; req_code = 3'b010;
        tick();
        chk("R7 granted", hlda, 1'b1);
        chk("R7 floated", {ad_oe, addr_hi_oe, ctrl_oe, iom_oe}, 4'b0000);
        tick();
        chk("R7 request blocked", {ale, hlda}, 2'b01);
        req_valid = 1'b0;
        hold = 1'b0;
        tick();
        chk("R8 released", {hlda, ctrl_oe, iom_oe}, 3'b011);

        // R9 halt
        halt_req = 1'b1;
        tick();
        chk("R9 halt status", {s1, s0, iom_oe, addr_hi_oe, ctrl_oe}, 5'b00001);
        // R13 request beats halt
        req_valid = 1'b1; req_code = 3'b110; req_addr = 16'h0077;
        tick();
        chk("R13 request over halt", {ale, iom_oe}, 2'b11);
        req_valid = 1'b0;
        tick(); tick();
        // R13 hold beats request at boundary (T3)
        hold = 1'b1; req_valid = 1'b1; req_code = 3'b011;
        tick();
        chk("R13 hold over request", {hlda, ale}, 2'b10);
        hold = 1'b0; req_valid = 1'b0; halt_req = 1'b0;
        tick();
        chk("R8 released again", hlda, 1'b0);
        tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule